// File: doc/BRIEF.md
# SDIO Register-Access Command Transmitter

This block issues single-byte register access commands (command index 52) to an SDIO card over the one-bit command line, and collects the card's reply. A host-side controller supplies the access fields (direction of access, function number, read-after-write request, 17-bit register address and a data byte) and pulses a start strobe. The block assembles the 48-bit command frame and computes its 7-bit CRC bit by bit as the frame goes out. It shifts the frame out most significant bit first, with each bit launched on a falling edge of the card clock that the block itself produces.

Once the end bit has gone out, the block releases the command line and watches for the card's start bit. It samples on one of two edges, selected per command. For a card in default timing it samples just before the rising edge. For a card in high-speed timing, which changes its output right after the rising edge, it samples just before the falling edge. The 48 received bits are checked for framing and CRC. A bounded wait produces a timeout if the card stays silent. A busy output covers the whole exchange, and a one-cycle done pulse marks its end.

Top module: `sdio_reg_cmd`

## Requirements
- R1: While reset is held, sd_clk, cmd_oe, busy, done, timeout and rsp_err are all 0 and the line stays released (high through the pull-up).
- R2: sd_clk runs freely from reset. It starts low, and each level lasts HALF_DIV system clock cycles.
- R3: The transmitted frame has 48 bits, sent most significant first. Bit 47 is the start bit 0 and bit 46 is the direction bit 1. Bits 45:40 hold the index 52 and bit 39 the write flag (1 = write). Bits 38:36 hold the function number and bit 35 the read-after-write flag. Bits 34 and 16 are stuff bits of value 0. Bits 33:17 hold the register address and bits 15:8 the data byte.
- R4: Bits 7:1 carry the CRC7 of bits 47:8, using generator x^7 + x^3 + 1 and a register cleared to zero. Bit 0 is the end bit 1.
- R5: cmd_out and cmd_oe change only in the system cycle in which sd_clk falls. cmd_oe is high for exactly the 48 bit periods of the command, and the first driven bit is 0.
- R6: With hs_mode = 0 at the start strobe, response bits are taken from the line level just before sd_clk rises. With hs_mode = 1 they are taken from the level just before sd_clk falls.
- R7: After release, the block checks for a start bit on each sampling edge. If RSP_TIMEOUT consecutive samples are all high, it sets timeout, pulses done and drops busy. A start bit seen on the last of those samples is still accepted.
- R8: After a start bit, 48 bits are captured into rsp_frame (first bit at bit 47), then done pulses. rsp_err is set when bit 46 is not 0, when bit 0 is not 1, or when bits 7:1 differ from the CRC7 of bits 47:8.
- R9: busy rises in the cycle after an accepted start and stays high until the cycle in which done pulses. A start strobe while busy is ignored, and so are field changes made during that time.
- R10: An accepted start clears timeout and rsp_err in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to issue a command |
| hs_mode | input | 1 | Response sampling select, captured at start (1 = high-speed timing) |
| wr_flag | input | 1 | Access direction, 1 = write |
| func_num | input | 3 | Target function number |
| raw_flag | input | 1 | Read-after-write request |
| reg_addr | input | 17 | Register address |
| wr_data | input | 8 | Byte to write |
| cmd_in | input | 1 | Level on the command line |
| sd_clk | output | 1 | Divided card clock |
| cmd_out | output | 1 | Command line drive value |
| cmd_oe | output | 1 | Command line drive enable |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | One-cycle pulse at the end of an exchange |
| timeout | output | 1 | No start bit within the wait window |
| rsp_err | output | 1 | Received frame failed a check |
| rsp_frame | output | 48 | Received response frame |

## Verification
The bench builds the block with HALF_DIV = 2 and the default RSP_TIMEOUT = 64. A card clock period of four system cycles keeps each exchange within a few hundred cycles. With these values, the 64-sample wait window can be hit exactly on both sides in both sampling modes: an idle gap of 62 card edges is accepted and 63 times out in default timing, and 63 against 64 in high-speed timing. The bench's card model changes the line on the edge that each mode implies. Sampling on the wrong edge therefore shifts the captured frame by one bit.

// File: rtl/sdio_cmd_pkg.sv
package sdio_cmd_pkg;

    localparam int FRAME_W = 48;
    localparam int HDR_W   = 40;
    localparam int CRC_W   = 7;
    localparam int ADDR_W  = 17;
    localparam int FUNC_W  = 3;
    localparam int DATA_W  = 8;

    localparam logic [5:0]       IDX_REG_RW = 6'd52;
    // x^7 + x^3 + 1 without the leading term
    localparam logic [CRC_W-1:0] CRC_TAPS   = 7'h09;

    // Header of the register access command, most significant field first
    typedef struct packed {
        logic              start;
        logic              host_dir;
        logic [5:0]        index;
        logic              wr;
        logic [FUNC_W-1:0] func;
        logic              raw;
        logic              pad_hi;
        logic [ADDR_W-1:0] addr;
        logic              pad_lo;
        logic [DATA_W-1:0] data;
    } reg_cmd_t;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_WAIT,
        RX_BODY
    } rx_state_e;

    // One serial step of the CRC7 register
    function automatic logic [CRC_W-1:0] crc7_step(input logic [CRC_W-1:0] c,
                                                   input logic             b);
        logic fb;
        fb = b ^ c[CRC_W-1];
        return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_TAPS : '0);
    endfunction

    function automatic reg_cmd_t pack_reg_cmd(input logic              wr,
                                              input logic [FUNC_W-1:0] func,
                                              input logic              raw,
                                              input logic [ADDR_W-1:0] addr,
                                              input logic [DATA_W-1:0] data);
        reg_cmd_t c;
        c.start    = 1'b0;
        c.host_dir = 1'b1;
        c.index    = IDX_REG_RW;
        c.wr       = wr;
        c.func     = func;
        c.raw      = raw;
        c.pad_hi   = 1'b0;
        c.addr     = addr;
        c.pad_lo   = 1'b0;
        c.data     = data;
        return c;
    endfunction

endpackage

// File: rtl/sdio_clk_div.sv
module sdio_clk_div #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    output logic sd_clk,
    output logic rise_evt,
    output logic fall_evt
);
    logic wrap;
    logic clk_q;

    generate
        if (HALF_DIV > 1) begin : g_count
            localparam int            CW   = $clog2(HALF_DIV);
            localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);
            logic [CW-1:0] cnt_q;

            assign wrap = (cnt_q == LAST);

            always_ff @(posedge clk) begin
                if (rst || wrap) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + CW'(1);
                end
            end
        end else begin : g_every
            assign wrap = 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_q <= 1'b0;
        end else if (wrap) begin
            clk_q <= ~clk_q;
        end
    end

    assign sd_clk   = clk_q;
    assign rise_evt = wrap & ~clk_q;
    assign fall_evt = wrap &  clk_q;

endmodule

// File: rtl/sdio_cmd_tx.sv
module sdio_cmd_tx
    import sdio_cmd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  reg_cmd_t hdr,
    input  logic     step,
    output logic     cmd_out,
    output logic     cmd_oe,
    output logic     active,
    output logic     last
);
    localparam logic [5:0] N_HDR    = 6'(HDR_W);
    localparam logic [5:0] END_POS  = 6'(FRAME_W - 1);
    localparam logic [5:0] DONE_POS = 6'(FRAME_W);

    logic [HDR_W-1:0] sh_q;
    logic [CRC_W-1:0] crc_q;
    logic [5:0]       pos_q;
    logic             act_q;
    logic             out_q;
    logic             oe_q;
    logic             nxt_bit;

    always_comb begin
        if (pos_q < N_HDR) begin
            nxt_bit = sh_q[HDR_W-1];
        end else if (pos_q < END_POS) begin
            nxt_bit = crc_q[CRC_W-1];
        end else begin
            nxt_bit = 1'b1;
        end
    end

    assign last = act_q && step && (pos_q == DONE_POS);

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= 1'b0;
            out_q <= 1'b1;
            oe_q  <= 1'b0;
            pos_q <= '0;
            sh_q  <= '0;
            crc_q <= '0;
        end else if (load && !act_q) begin
            act_q <= 1'b1;
            sh_q  <= hdr;
            pos_q <= '0;
            crc_q <= '0;
        end else if (act_q && step) begin
            if (pos_q == DONE_POS) begin
                act_q <= 1'b0;
                oe_q  <= 1'b0;
                out_q <= 1'b1;
            end else begin
                out_q <= nxt_bit;
                oe_q  <= 1'b1;
                pos_q <= pos_q + 6'd1;
                if (pos_q < N_HDR) begin
                    crc_q <= crc7_step(crc_q, nxt_bit);
                    sh_q  <= {sh_q[HDR_W-2:0], 1'b0};
                end else begin
                    crc_q <= {crc_q[CRC_W-2:0], 1'b0};
                end
            end
        end
    end

    assign cmd_out = out_q;
    assign cmd_oe  = oe_q;
    assign active  = act_q;

endmodule

// File: rtl/sdio_rsp_rx.sv
module sdio_rsp_rx
    import sdio_cmd_pkg::*;
#(
    parameter int TIMEOUT = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               arm,
    input  logic               smp,
    input  logic               din,
    output logic               active,
    output logic               done,
    output logic               timeout,
    output logic               err,
    output logic [FRAME_W-1:0] frame
);
    localparam int            TW        = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
    localparam logic [TW-1:0] LAST_WAIT = TW'(TIMEOUT - 1);
    localparam logic [5:0]    N_HDR     = 6'(HDR_W);
    localparam logic [5:0]    LAST_POS  = 6'(FRAME_W - 1);

    rx_state_e        st_q;
    logic [5:0]       cnt_q;
    logic [FRAME_W-1:0] sh_q;
    logic [CRC_W-1:0] crc_q;
    logic [TW-1:0]    wait_q;
    logic             done_q;
    logic             to_q;
    logic             err_q;
    logic [FRAME_W-1:0] full;
    logic             bad;

    assign full = {sh_q[FRAME_W-2:0], din};
    assign bad  = full[FRAME_W-1] | full[FRAME_W-2] | ~full[0] |
                  (crc_q != full[CRC_W:1]);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= RX_IDLE;
            cnt_q  <= '0;
            sh_q   <= '0;
            crc_q  <= '0;
            wait_q <= '0;
            done_q <= 1'b0;
            to_q   <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (clr) begin
                to_q  <= 1'b0;
                err_q <= 1'b0;
            end
            case (st_q)
                RX_IDLE: begin
                    if (arm) begin
                        st_q   <= RX_WAIT;
                        wait_q <= '0;
                        crc_q  <= '0;
                        cnt_q  <= '0;
                    end
                end
                RX_WAIT: begin
                    if (smp) begin
                        if (!din) begin
                            sh_q  <= {sh_q[FRAME_W-2:0], 1'b0};
                            crc_q <= crc7_step(crc_q, 1'b0);
                            cnt_q <= 6'd1;
                            st_q  <= RX_BODY;
                        end else if (wait_q == LAST_WAIT) begin
                            to_q   <= 1'b1;
                            done_q <= 1'b1;
                            st_q   <= RX_IDLE;
                        end else begin
                            wait_q <= wait_q + TW'(1);
                        end
                    end
                end
                RX_BODY: begin
                    if (smp) begin
                        sh_q <= full;
                        if (cnt_q < N_HDR) begin
                            crc_q <= crc7_step(crc_q, din);
                        end
                        if (cnt_q == LAST_POS) begin
                            err_q  <= bad;
                            done_q <= 1'b1;
                            st_q   <= RX_IDLE;
                        end else begin
                            cnt_q <= cnt_q + 6'd1;
                        end
                    end
                end
                default: st_q <= RX_IDLE;
            endcase
        end
    end

    assign active  = (st_q != RX_IDLE);
    assign done    = done_q;
    assign timeout = to_q;
    assign err     = err_q;
    assign frame   = sh_q;

endmodule

// File: rtl/sdio_reg_cmd.sv
module sdio_reg_cmd
    import sdio_cmd_pkg::*;
#(
    parameter int HALF_DIV    = 2,
    parameter int RSP_TIMEOUT = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        hs_mode,
    input  logic        wr_flag,
    input  logic [2:0]  func_num,
    input  logic        raw_flag,
    input  logic [16:0] reg_addr,
    input  logic [7:0]  wr_data,
    input  logic        cmd_in,
    output logic        sd_clk,
    output logic        cmd_out,
    output logic        cmd_oe,
    output logic        busy,
    output logic        done,
    output logic        timeout,
    output logic        rsp_err,
    output logic [47:0] rsp_frame
);
    logic     rise_evt;
    logic     fall_evt;
    logic     smp_evt;
    logic     hs_q;
    logic     accept;
    logic     tx_active;
    logic     tx_last;
    logic     rx_active;
    reg_cmd_t hdr;

    assign busy   = tx_active | rx_active;
    assign accept = start & ~busy;
    assign hdr    = pack_reg_cmd(wr_flag, func_num, raw_flag, reg_addr, wr_data);

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_q <= 1'b0;
        end else if (accept) begin
            hs_q <= hs_mode;
        end
    end

    // Default timing: level before the rising edge. High-speed: before the falling edge.
    assign smp_evt = hs_q ? fall_evt : rise_evt;

    sdio_clk_div #(
        .HALF_DIV (HALF_DIV)
    ) u_clk (
        .clk      (clk),
        .rst      (rst),
        .sd_clk   (sd_clk),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt)
    );

    sdio_cmd_tx u_tx (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .hdr     (hdr),
        .step    (fall_evt),
        .cmd_out (cmd_out),
        .cmd_oe  (cmd_oe),
        .active  (tx_active),
        .last    (tx_last)
    );

    sdio_rsp_rx #(
        .TIMEOUT (RSP_TIMEOUT)
    ) u_rx (
        .clk     (clk),
        .rst     (rst),
        .clr     (accept),
        .arm     (tx_last),
        .smp     (smp_evt),
        .din     (cmd_in),
        .active  (rx_active),
        .done    (done),
        .timeout (timeout),
        .err     (rsp_err),
        .frame   (rsp_frame)
    );

endmodule

// File: rtl/sdio_reg_cmd_chk.sv
module sdio_reg_cmd_chk (
    input logic clk,
    input logic rst,
    input logic start,
    input logic sd_clk,
    input logic cmd_out,
    input logic cmd_oe,
    input logic busy,
    input logic done,
    input logic timeout,
    input logic rsp_err
);
    a_r5_change_on_fall: assert property (@(posedge clk) disable iff (rst)
        (!$stable(cmd_out) || !$stable(cmd_oe)) |-> $fell(sd_clk));

    a_r5_first_bit_zero: assert property (@(posedge clk) disable iff (rst)
        $rose(cmd_oe) |-> (cmd_out == 1'b0));

    a_r9_drive_within_busy: assert property (@(posedge clk) disable iff (rst)
        cmd_oe |-> busy);

    a_r9_busy_ends_with_done: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    a_r9_done_not_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    a_r7_timeout_with_done: assert property (@(posedge clk) disable iff (rst)
        $rose(timeout) |-> done);

    a_r8_error_with_done: assert property (@(posedge clk) disable iff (rst)
        $rose(rsp_err) |-> done);

    a_r10_flags_cleared: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (!timeout && !rsp_err));

endmodule

bind sdio_reg_cmd sdio_reg_cmd_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .sd_clk  (sd_clk),
    .cmd_out (cmd_out),
    .cmd_oe  (cmd_oe),
    .busy    (busy),
    .done    (done),
    .timeout (timeout),
    .rsp_err (rsp_err)
);

// File: tb/sdio_reg_cmd_bench.sv
`timescale 1ns/1ps
module sdio_reg_cmd_bench;
    localparam int HALF = 2;
    localparam int TMO  = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic        start = 1'b0, hs_mode = 1'b0, wr_flag = 1'b0, raw_flag = 1'b0;
    logic [2:0]  func_num = '0;
    logic [16:0] reg_addr = '0;
    logic [7:0]  wr_data  = '0;
    logic        card_drv = 1'b1;
    logic        cmd_line;
    logic        sd_clk, cmd_out, cmd_oe, busy, done, timeout, rsp_err;
    logic [47:0] rsp_frame;

    // Released line is pulled high unless the card model drives it
    assign cmd_line = cmd_oe ? cmd_out : card_drv;

    sdio_reg_cmd #(.HALF_DIV(HALF), .RSP_TIMEOUT(TMO)) u_sdio_reg_cmd (
        .clk(clk), .rst(rst), .start(start), .hs_mode(hs_mode), .wr_flag(wr_flag),
        .func_num(func_num), .raw_flag(raw_flag), .reg_addr(reg_addr), .wr_data(wr_data),
        .cmd_in(cmd_line), .sd_clk(sd_clk), .cmd_out(cmd_out), .cmd_oe(cmd_oe),
        .busy(busy), .done(done), .timeout(timeout), .rsp_err(rsp_err), .rsp_frame(rsp_frame)
    );

    int n_checks = 0;
    int n_errors = 0;
    int n_edges  = 0;
    bit finished = 0;

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // R2 model: clock level from the count of edges since reset
    always @(posedge clk) n_edges <= rst ? 0 : n_edges + 1;
    always @(negedge clk)
        if (!rst && !finished)
            chk("R2", "sd_clk level", 64'(sd_clk), 64'((n_edges / HALF) % 2));

    // Remainder by long division with 0x89
    function automatic logic [6:0] ref_crc(input logic [39:0] v);
        logic [46:0] m;
        m = {v, 7'b0};
        for (int i = 46; i >= 7; i--)
            if (m[i]) m = m ^ (47'h89 << (i - 7));
        return m[6:0];
    endfunction

    function automatic logic [47:0] cmd_frame(input logic wr, input logic [2:0] fn,
            input logic raw, input logic [16:0] addr, input logic [7:0] dat);
        logic [39:0] h;
        h = {1'b0, 1'b1, 6'd52, wr, fn, raw, 1'b0, addr, 1'b0, dat};
        return {h, ref_crc(h), 1'b1};
    endfunction

    // kind: 0 good, 1 bad crc, 2 bad direction, 3 bad end bit
    function automatic logic [47:0] rsp_build(input logic [7:0] dat, input int kind);
        logic [39:0] h;
        logic [6:0]  c;
        h = {1'b0, (kind == 2), 6'd52, 16'h0000, 8'h10, dat};
        c = ref_crc(h);
        if (kind == 1) c = c ^ 7'h01;
        return {h, c, (kind != 3)};
    endfunction

    // kind 4: the card never answers
    task automatic run_txn(input string tag, input bit wr, input logic [2:0] fn,
            input bit raw, input logic [16:0] addr, input logic [7:0] dat,
            input bit hs, input int kind, input int gap, input bit poke);
        logic [47:0] exp_cmd, rsp, got;
        int  ncap = 0, edges = 0, ridx = 0;
        bit  released = 0, seen_done = 0, exp_to, exp_err, rose, fell;
        logic pclk, pout, poe;
        exp_cmd = cmd_frame(wr, fn, raw, addr, dat);
        rsp     = rsp_build(dat ^ 8'h5a, kind);
        got     = '0;
        exp_to  = (kind == 4) || (hs ? (gap >= TMO) : (gap >= TMO - 1));
        exp_err = !exp_to && (kind >= 1) && (kind <= 3);

        @(negedge clk);
        wr_flag = wr; func_num = fn; raw_flag = raw; reg_addr = addr; wr_data = dat;
        hs_mode = hs; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R9", {tag, " busy after start"}, 64'(busy), 64'd1);
        chk("R10", {tag, " timeout cleared"}, 64'(timeout), 64'd0);
        chk("R10", {tag, " rsp_err cleared"}, 64'(rsp_err), 64'd0);
        pclk = sd_clk; pout = cmd_out; poe = cmd_oe;

        for (int cyc = 0; cyc < 4000 && !seen_done; cyc++) begin
            @(negedge clk);
            if (poke && cyc == 20) begin
                start = 1'b1; reg_addr = ~addr; wr_data = ~dat; wr_flag = ~wr;
            end else begin
                start = 1'b0;
            end
            rose = !pclk && sd_clk;
            fell = pclk && !sd_clk;
            if ((cmd_out !== pout) || (cmd_oe !== poe))
                chk("R5", {tag, " line change on falling edge"}, 64'(fell), 64'd1);
            if (rose && cmd_oe && ncap < 48) begin
                got = {got[46:0], cmd_out};
                ncap++;
            end
            if (released && kind != 4 && (hs ? rose : fell)) begin
                if (edges < gap) edges++;
                else if (ridx < 48) begin card_drv = rsp[47 - ridx]; ridx++; end
                else card_drv = 1'b1;
            end
            if (poe && !cmd_oe) released = 1;
            if (done) seen_done = 1;
            else chk("R9", {tag, " busy held"}, 64'(busy), 64'd1);
            pclk = sd_clk; pout = cmd_out; poe = cmd_oe;
        end
        card_drv = 1'b1;

        chk("R9", {tag, " done seen"}, 64'(seen_done), 64'd1);
        chk("R9", {tag, " busy low at done"}, 64'(busy), 64'd0);
        chk("R5", {tag, " bits driven"}, 64'(ncap), 64'd48);
        chk("R3", {tag, " header bits"}, 64'(got[47:8]), 64'(exp_cmd[47:8]));
        chk("R4", {tag, " crc and end"}, 64'(got[7:0]), 64'(exp_cmd[7:0]));
        chk("R7", {tag, " timeout flag"}, 64'(timeout), 64'(exp_to));
        chk("R8", {tag, " rsp_err flag"}, 64'(rsp_err), 64'(exp_err));
        if (!exp_to)
            chk("R6/R8", {tag, " captured frame"}, 64'(rsp_frame), 64'(rsp));
        repeat (3) begin
            @(negedge clk);
            chk("R9", {tag, " stays idle"}, 64'({busy, cmd_oe, done}), 64'd0);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk("R1", "reset outputs", 64'({sd_clk, cmd_oe, busy, done, timeout, rsp_err}), 64'd0);
        chk("R1", "line released high", 64'(cmd_line), 64'd1);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        run_txn("write default", 1'b1, 3'd1, 1'b1, 17'h12345, 8'hA5, 1'b0, 0, 2, 1'b0);
        run_txn("read highspeed", 1'b0, 3'd2, 1'b0, 17'h1FFFF, 8'h00, 1'b1, 0, 0, 1'b0);
        run_txn("zero fields", 1'b0, 3'd0, 1'b0, 17'h00000, 8'h00, 1'b0, 0, 1, 1'b0);
        run_txn("bad crc", 1'b1, 3'd7, 1'b0, 17'h0A5A5, 8'h3C, 1'b0, 1, 5, 1'b0);
        run_txn("bad dir hs", 1'b0, 3'd3, 1'b1, 17'h10001, 8'h81, 1'b1, 2, 3, 1'b0);
        run_txn("bad end", 1'b1, 3'd4, 1'b0, 17'h00F0F, 8'hFF, 1'b0, 3, 2, 1'b0);
        run_txn("silent card", 1'b1, 3'd1, 1'b0, 17'h00100, 8'h11, 1'b0, 4, 0, 1'b0);
        run_txn("R10 after timeout", 1'b0, 3'd5, 1'b1, 17'h0ABCD, 8'h22, 1'b0, 0, 1, 1'b0);
        run_txn("R7 last default", 1'b0, 3'd1, 1'b0, 17'h00042, 8'h33, 1'b0, 0, 62, 1'b0);
        run_txn("R7 over default", 1'b0, 3'd1, 1'b0, 17'h00043, 8'h44, 1'b0, 0, 63, 1'b0);
        run_txn("R7 last hs", 1'b1, 3'd6, 1'b0, 17'h00044, 8'h55, 1'b1, 0, 63, 1'b0);
        run_txn("R7 over hs", 1'b1, 3'd6, 1'b0, 17'h00045, 8'h66, 1'b1, 0, 64, 1'b0);
        run_txn("R9 start while busy", 1'b1, 3'd2, 1'b1, 17'h05555, 8'h96, 1'b0, 0, 4, 1'b1);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule